// File: doc/BRIEF.md
# Programmable Priority Channel Arbiter

This block decides which of several transfer channels the transfer engine serves next. A channel can ask for service in two ways: through its own hardware request line, or through a software trigger pulse. A trigger pulse is latched and stays pending until that channel has been granted once. Requests from a channel whose enable bit is low are ignored, and any trigger it had latched is dropped.

Software gives each channel one of four priority levels. The arbiter grants the pending channel with the highest level. When several pending channels share that level, the lowest channel index wins. The result is a one-hot grant vector, the index of the granted channel and a valid flag.

A grant stays in place until the transfer engine pulses beat-done. Arbitration is evaluated again only at that point, or whenever no grant is held, so a channel is never displaced in the middle of a beat.

Top module: `dma_prio_arbiter`

## Requirements
- R1: When no grant is held, an enabled channel whose hardware request is high is granted at the next rising clock edge, with the valid flag high.
- R2: A one-cycle pulse on a channel's software trigger counts as a request, including in the cycle of the pulse. It stays pending across cycles until that channel is granted. After that grant it is cleared and raises no second grant.
- R3: Channel c's level is the 2-bit field at bits [2c+1:2c] of the level input (3 = very high, 2 = high, 1 = medium, 0 = low). The arbiter grants a pending channel whose level is the highest among the pending channels.
- R4: Among pending channels that share the highest level, the channel with the lowest index is granted.
- R5: A channel whose enable bit is low is never granted from its hardware request or its software trigger. A trigger latched while the channel was enabled is dropped once the enable bit goes low.
- R6: While a grant is held and beat-done is low, the grant, index and valid outputs stay unchanged whatever the requests do. At an edge where beat-done is high, a fresh decision is loaded from the requests present in that cycle.
- R7: The grant output is one-hot when valid is high. The index output is the bit position of that one-hot grant.
- R8: When an arbitration finds nothing pending, the grant output is all zeros, the index is 0 and the valid flag is low.
- R9: Reset clears the grant, the index, the valid flag and every latched software trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_req | input | NUM_CH | Hardware request line per channel |
| sw_trig | input | NUM_CH | Software trigger pulse per channel |
| chan_en | input | NUM_CH | Channel enable bits |
| prio_lvl | input | 2*NUM_CH | Packed 2-bit priority level per channel |
| beat_done | input | 1 | Transfer engine finished the current beat |
| grant | output | NUM_CH | One-hot grant |
| grant_idx | output | $clog2(NUM_CH) | Index of the granted channel |
| grant_valid | output | 1 | A channel is granted |

## Verification
The table of patterns covers several cases. A lone request checks basic granting. All channels at equal level check the index tie-break. A single raised level checks that level outranks index. Two channels tied above the rest check that the tie-break applies within the top level only. A disabled channel holding the top level checks that enables mask requests. Mixes of hardware requests and trigger pulses check that the two request sources are merged. Directed sequences cover other cases. Requests change while beat-done is low, which separates a held grant from one that is re-evaluated every cycle. A losing trigger is later served and then gone, which separates a latched trigger from a level-sensitive or sticky one. Disable and reset sequences show that a latched trigger is removed.

// File: rtl/dma_prio_arbiter_pkg.sv
package dma_prio_arbiter_pkg;

  localparam int PRIO_W = 2;
  localparam int NLVL   = 1 << PRIO_W;

  typedef enum logic [PRIO_W-1:0] {
    LVL_LOW   = 2'd0,
    LVL_MED   = 2'd1,
    LVL_HIGH  = 2'd2,
    LVL_VHIGH = 2'd3
  } prio_lvl_e;

  // a outranks b: higher level, or same level and lower index
  function automatic logic outranks(input logic [PRIO_W-1:0] a_lvl, input int a_idx,
                                    input logic [PRIO_W-1:0] b_lvl, input int b_idx);
    if (a_lvl > b_lvl) return 1'b1;
    if (a_lvl == b_lvl && a_idx < b_idx) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/dma_arb_req_merge.sv
module dma_arb_req_merge #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] take,
  output logic [NUM_CH-1:0] req_vec,
  output logic [NUM_CH-1:0] sw_pend
);

  logic [NUM_CH-1:0] sw_pend_nxt;

  // a trigger counts in its own cycle and afterwards while latched
  assign req_vec     = (hw_req | sw_pend | sw_trig) & chan_en;
  assign sw_pend_nxt = (sw_pend | sw_trig) & chan_en & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pend <= '0;
    else        sw_pend <= sw_pend_nxt;
  end

  // R2
  sw_clear_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|take) |=> ((sw_pend & $past(take)) == '0));

  // R5
  sw_drop_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sw_pend & ~$past(chan_en)) == '0));

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_prio_arbiter_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] lvl_flat,
  output logic [NUM_CH-1:0]        win,
  output logic [IW-1:0]            win_idx
);

  logic [NUM_CH-1:0] lvl_hit [NLVL];
  logic [NUM_CH-1:0] top_set;

  function automatic logic [NUM_CH-1:0] lowest_one(input logic [NUM_CH-1:0] v);
    return v & (~v + NUM_CH'(1));
  endfunction

  function automatic logic [IW-1:0] oh_to_idx(input logic [NUM_CH-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (oh[c]) r = r | IW'(c);
    return r;
  endfunction

  // one request mask per priority level
  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lvl_hit[l][c] = req[c] & (lvl_flat[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
  end

  // highest non-empty level wins; later (higher) levels override
  always_comb begin
    top_set = '0;
    for (int l = 0; l < NLVL; l++)
      if (|lvl_hit[l]) top_set = lvl_hit[l];
  end

  assign win     = lowest_one(top_set);
  assign win_idx = oh_to_idx(win);

endmodule

// File: rtl/dma_arb_grant_hold.sv
module dma_arb_grant_hold #(
  parameter int NUM_CH = 8,
  localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_done,
  input  logic [NUM_CH-1:0] win,
  input  logic [IW-1:0]     win_idx,
  output logic              upd,
  output logic [NUM_CH-1:0] grant,
  output logic [IW-1:0]     grant_idx,
  output logic              grant_valid
);

  // re-evaluate only when idle or at the end of a beat
  assign upd = !grant_valid || beat_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_idx   <= '0;
      grant_valid <= 1'b0;
    end else if (upd) begin
      grant       <= win;
      grant_idx   <= win_idx;
      grant_valid <= |win;
    end
  end

  // R6
  hold_mid_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !beat_done) |=> ($stable(grant) && $stable(grant_idx) && grant_valid));

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($onehot(grant) && grant[grant_idx]));

  // R8
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && win == '0) |=> (!grant_valid && grant == '0 && grant_idx == '0));

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_prio_arbiter_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        hw_req,
  input  logic [NUM_CH-1:0]        sw_trig,
  input  logic [NUM_CH-1:0]        chan_en,
  input  logic [NUM_CH*PRIO_W-1:0] prio_lvl,
  input  logic                     beat_done,
  output logic [NUM_CH-1:0]        grant,
  output logic [IW-1:0]            grant_idx,
  output logic                     grant_valid
);

  logic [NUM_CH-1:0] req_vec;
  logic [NUM_CH-1:0] sw_pend;
  logic [NUM_CH-1:0] win;
  logic [IW-1:0]     win_idx;
  logic [NUM_CH-1:0] take;
  logic              upd;
  logic              outranked;

  dma_arb_req_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_req  (hw_req),
    .sw_trig (sw_trig),
    .chan_en (chan_en),
    .take    (take),
    .req_vec (req_vec),
    .sw_pend (sw_pend)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req      (req_vec),
    .lvl_flat (prio_lvl),
    .win      (win),
    .win_idx  (win_idx)
  );

  dma_arb_grant_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_done   (beat_done),
    .win         (win),
    .win_idx     (win_idx),
    .upd         (upd),
    .grant       (grant),
    .grant_idx   (grant_idx),
    .grant_valid (grant_valid)
  );

  // channel whose grant is being issued this cycle
  assign take = upd ? win : '0;

  // independent ranking check: no requester beats the chosen winner
  always_comb begin
    outranked = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (req_vec[c] && outranks(prio_lvl[c*PRIO_W +: PRIO_W], c,
                                 prio_lvl[int'(win_idx)*PRIO_W +: PRIO_W], int'(win_idx)))
        outranked = 1'b1;
  end

  // R3 R4
  prio_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_vec) |-> (!outranked && req_vec[win_idx]));

  // R5
  granted_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && |req_vec) |=> ((grant & $past(chan_en)) != '0));

  // R1
  idle_serves_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && |(hw_req & chan_en)) |=> grant_valid);

endmodule

// File: tb/sim_dma_prio_arbiter.sv
module sim_dma_prio_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int NVEC = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] hw_req = '0;
  logic [N-1:0] sw_trig = '0;
  logic [N-1:0] chan_en = '0;
  logic [2*N-1:0] prio_lvl = '0;
  logic         beat_done = 1'b0;
  logic [N-1:0] grant;
  logic [1:0]   grant_idx;
  logic         grant_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arbiter #(.NUM_CH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_trig(sw_trig),
    .chan_en(chan_en), .prio_lvl(prio_lvl), .beat_done(beat_done),
    .grant(grant), .grant_idx(grant_idx), .grant_valid(grant_valid)
  );

  // {enable, hw_req, sw_trig, levels {p3,p2,p1,p0}, expected grant}
  localparam logic [23:0] VECS [NVEC] = '{
    {4'b1111, 4'b0001, 4'b0000, 8'b00_00_00_00, 4'b0001},
    {4'b1111, 4'b1111, 4'b0000, 8'b00_00_00_00, 4'b0001},
    {4'b1111, 4'b1111, 4'b0000, 8'b11_00_00_00, 4'b1000},
    {4'b1111, 4'b0110, 4'b0000, 8'b00_10_10_00, 4'b0010},
    {4'b1111, 4'b0110, 4'b0000, 8'b00_11_01_00, 4'b0100},
    {4'b1011, 4'b1111, 4'b0000, 8'b01_11_00_00, 4'b1000},
    {4'b1111, 4'b0000, 4'b0100, 8'b00_00_00_00, 4'b0100},
    {4'b1111, 4'b0000, 4'b0000, 8'b00_00_00_00, 4'b0000},
    {4'b0000, 4'b1111, 4'b1111, 8'b11_11_11_11, 4'b0000},
    {4'b1111, 4'b0001, 4'b1000, 8'b00_00_00_01, 4'b0001},
    {4'b1111, 4'b1010, 4'b0000, 8'b10_00_10_00, 4'b0010},
    {4'b1111, 4'b1000, 4'b0000, 8'b00_00_00_00, 4'b1000}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:       return "R1";
      1, 3, 10: return "R4";
      2, 4, 9: return "R3";
      5, 8:    return "R5";
      6:       return "R2";
      7:       return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [N-1:0] exp_g);
    logic [1:0] exp_i;
    logic       exp_v;
    exp_i = '0;
    for (int c = 0; c < N; c++) if (exp_g[c]) exp_i = 2'(c);
    exp_v = |exp_g;
    checks++;
    if (grant !== exp_g || grant_idx !== exp_i || grant_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
               tag, grant, grant_idx, grant_valid, exp_g, exp_i, exp_v);
    end
  endtask

  task automatic step(input logic [N-1:0] en, input logic [N-1:0] hw,
                      input logic [N-1:0] sw, input logic [2*N-1:0] lv, input logic bd);
    chan_en = en; hw_req = hw; sw_trig = sw; prio_lvl = lv; beat_done = bd;
    @(negedge clk);
    sw_trig = '0;
  endtask

  task automatic drain();
    step(4'b0000, 4'b0000, 4'b0000, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][23:20], VECS[i][19:16], VECS[i][15:12], VECS[i][11:4], 1'b1);
      check(vec_tag(i), VECS[i][3:0]);
      drain();
    end

    // R6 hold until beat-done
    step(4'b1111, 4'b0001, 4'b0000, 8'b00_00_00_00, 1'b0);
    check("R1", 4'b0001);
    step(4'b1111, 4'b1000, 4'b0000, 8'b11_00_00_00, 1'b0);
    check("R6", 4'b0001);
    step(4'b1111, 4'b1000, 4'b0000, 8'b11_00_00_00, 1'b0);
    check("R6", 4'b0001);
    step(4'b1111, 4'b1000, 4'b0000, 8'b11_00_00_00, 1'b1);
    check("R6", 4'b1000);
    step(4'b1111, 4'b0000, 4'b0000, 8'b00_00_00_00, 1'b1);
    check("R8", 4'b0000);

    // R2 latched trigger served later, then cleared
    step(4'b1111, 4'b0001, 4'b0100, 8'b00_00_00_11, 1'b1);
    check("R3", 4'b0001);
    step(4'b1111, 4'b0000, 4'b0000, 8'b00_00_00_11, 1'b1);
    check("R2", 4'b0100);
    step(4'b1111, 4'b0000, 4'b0000, 8'b00_00_00_11, 1'b1);
    check("R2", 4'b0000);

    // R5 latched trigger dropped by disable
    step(4'b1111, 4'b0001, 4'b0010, 8'b00_00_00_11, 1'b1);
    check("R3", 4'b0001);
    step(4'b1101, 4'b0000, 4'b0000, 8'b00_00_00_11, 1'b0);
    check("R6", 4'b0001);
    step(4'b1111, 4'b0000, 4'b0000, 8'b00_00_00_11, 1'b1);
    check("R5", 4'b0000);

    // R9 reset clears a latched trigger
    step(4'b1111, 4'b0001, 4'b0100, 8'b00_00_00_11, 1'b1);
    check("R3", 4'b0001);
    rst_n = 1'b0;
    hw_req = '0;
    repeat (2) @(negedge clk);
    check("R9", 4'b0000);
    rst_n = 1'b1;
    step(4'b1111, 4'b0000, 4'b0000, 8'b00_00_00_11, 1'b1);
    check("R9", 4'b0000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule